// File: doc/BRIEF.md
# USB 1.x Host Controller Register Block

This block is the software-visible register set of a two-port USB 1.x host controller. Software reaches it through a small I/O window: a 5-bit address, a transfer size of byte, word or dword, a write strobe and write data. Reads are combinational from the same address and size. The block holds the command word, the status flags, the interrupt enables, an 11-bit frame counter value, a 4 KiB-aligned frame list base address and an 8-bit start-of-frame timing value. It also holds one status/control word for each root port.

The schedule engine raises status flags through single-cycle set pulses. It reports completion and short-packet causes separately, and those causes are kept in a hidden two-bit register. The causes, the error flags and the enable word are combined into one level-sensitive interrupt line. The block emits three kinds of single-cycle pulse: run start, bus-wide reset and per-port device reset. Port attach and detach events arrive as single-cycle inputs for each port. The rest of the controller reads the run flag, the frame number and the list base from dedicated outputs.

Top module: `usbh_regfile`

## Requirements
- R1: After rst_n, command, status, interrupt enable, frame number and list base read 0. Start-of-frame timing reads 64. Each port word reads 0x0080, and irq is 0.
- R2: A word write to 0x00 without bits 1 or 2 set stores the value, and bit 0 drives `run`. `run_start` pulses for one cycle after a write that sets bit 0 while bit 0 was clear.
- R3: A command write with bit 1 or bit 2 set is not stored. It returns command, status, hidden causes, enables, list base, start-of-frame timing and ports to their reset values, and the frame number is kept. Each port with a device present comes back with bit 0 (connected) and bit 1 (connect change) set and bit 8 giving the device speed. Bit 2 also pulses `bus_reset` for one cycle.
- R4: The status word at 0x02 has these bits: 0 interrupt, 1 transfer error, 2 resume, 3 system error, 4 process error, 5 halted. Writing 1 to a bit clears it. Writing 1 to bit 0 also clears both hidden causes.
- R5: `sts_set[k]` sets status bit k, and it wins over a clear of the same bit in the same cycle. Any `cause_set` bit sets status bit 0 and latches a hidden cause: bit 0 means completion and bit 1 means short packet.
- R6: irq is high exactly when one of these holds: completion cause and enable bit 2, short cause and enable bit 3, status bit 1 and enable bit 0, status bit 2 and enable bit 1, status bit 3, or status bit 4. The enable word is at 0x04.
- R7: A word write to 0x06 loads the 11-bit frame number only while status bit 5 is set. Otherwise it is ignored.
- R8: A dword write to 0x08 stores the list base with bits 11:0 forced to 0. A byte write to 0x0C stores the start-of-frame timing.
- R9: A word write at 0x10 + 2*n reaches port n, with n taken from address bits 3:1. Bits 2, 9 and 15:10 take the written value and all other bits keep their value. Writing 1 to bit 1 or bit 3 clears that bit.
- R10: A port write that takes bit 9 from 0 to 1 while a device is present pulses that port's `port_reset` for one cycle.
- R11: Attach sets bits 0 and 1 if bit 0 was clear and copies the speed input to bit 8. Detach clears bit 2 and sets bit 3 if bit 2 was set.
- R12: Word reads of unmapped addresses, or of port slots at or above the port count, return 0xFF7F. Dword reads other than 0x08 return 0xFFFFFFFF. Byte reads other than 0x0C return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Register address |
| bus_size | input | 2 | 0 byte, 1 word, 2 dword |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr/bus_size |
| sts_set | input | 6 | Status set pulses from schedule logic |
| cause_set | input | 2 | Completion / short-packet cause pulses |
| port_attach | input | NPORTS | Device attach event per port |
| port_detach | input | NPORTS | Device detach event per port |
| port_low_speed | input | NPORTS | Speed of the attaching device (1 = low) |
| irq | output | 1 | Level interrupt |
| run | output | 1 | Run flag |
| frame_num | output | 11 | Frame number |
| list_base | output | 32 | Frame list base address |
| run_start | output | 1 | Pulse: run flag set from clear |
| bus_reset | output | 1 | Pulse: global bus reset |
| port_reset | output | NPORTS | Pulse per port: device reset |

## Verification
The hardest cases to reach are the hidden cause bits, because software cannot read them. The bench observes them only through irq. For each of the sixteen cause and error combinations it sweeps all sixteen enable patterns. It also checks that a status write without bit 0 leaves a cause in place, while a write with bit 0 removes it. Port words are driven through a long arithmetic sequence of writes with attach and detach events between them, so that the merge of kept, written and write-one-to-clear bits is checked from many prior states.

// File: rtl/usbh_pkg.sv
// Package: shared constants for the USB host controller register block.
// Assumes a 5-bit register window and 16-bit port words.
package usbh_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } xfer_size_e;

    localparam logic [4:0] A_CMD  = 5'h00;
    localparam logic [4:0] A_STS  = 5'h02;
    localparam logic [4:0] A_IEN  = 5'h04;
    localparam logic [4:0] A_FRN  = 5'h06;
    localparam logic [4:0] A_BASE = 5'h08;
    localparam logic [4:0] A_SOF  = 5'h0C;

    localparam logic [15:0] PORT_KEEP    = 16'h01FB;
    localparam logic [15:0] PORT_W1C     = 16'h000A;
    localparam logic [15:0] PORT_RST_VAL = 16'h0080;
    localparam logic [15:0] WORD_NONE    = 16'hFF7F;

    localparam int PB_CONN     = 0;
    localparam int PB_CONN_CHG = 1;
    localparam int PB_EN       = 2;
    localparam int PB_EN_CHG   = 3;
    localparam int PB_LS       = 8;
    localparam int PB_RST      = 9;

    localparam int SB_INT  = 0;
    localparam int SB_ERR  = 1;
    localparam int SB_RD   = 2;
    localparam int SB_HSE  = 3;
    localparam int SB_PERR = 4;
    localparam int SB_HALT = 5;

    localparam int STS_W   = 6;
    localparam int CAUSE_W = 2;
    localparam logic [7:0] SOF_RST = 8'd64;
endpackage

// File: rtl/usbh_port_reg.sv
// Module: one root-port status/control word.
// Merges software writes (kept, written and write-one-to-clear bits) with
// attach/detach events, and remembers whether a device is present so that a
// controller reset can restore the connection bits. Assumes that soft_rst and
// wr_en are never asserted in the same cycle as a port write is meaningful.
module usbh_port_reg
    import usbh_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    input  logic        attach,
    input  logic        detach,
    input  logic        low_speed,
    output logic [15:0] ctrl,
    output logic        rst_pulse
);
    logic        present;
    logic        dev_ls;
    logic [15:0] nxt;

    // Next port word: reset/write first, then attach/detach events on top.
    always_comb begin
        nxt = ctrl;
        if (soft_rst) begin
            nxt = PORT_RST_VAL;
            if (present) begin
                nxt[PB_CONN]     = 1'b1;
                nxt[PB_CONN_CHG] = 1'b1;
                nxt[PB_LS]       = dev_ls;
            end
        end else if (wr_en) begin
            nxt = (ctrl & PORT_KEEP) | (wdata & ~PORT_KEEP);
            nxt = nxt & ~(wdata & PORT_W1C);
        end
        if (attach) begin
            if (!nxt[PB_CONN]) begin
                nxt[PB_CONN]     = 1'b1;
                nxt[PB_CONN_CHG] = 1'b1;
            end
            nxt[PB_LS] = low_speed;
        end
        if (detach && nxt[PB_EN]) begin
            nxt[PB_EN]     = 1'b0;
            nxt[PB_EN_CHG] = 1'b1;
        end
    end

    // Register the port word, device presence and the reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= PORT_RST_VAL;
            present   <= 1'b0;
            dev_ls    <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            ctrl      <= nxt;
            rst_pulse <= wr_en && !soft_rst && wdata[PB_RST] && !ctrl[PB_RST] && present;
            if (detach) begin
                present <= 1'b0;
            end else if (attach) begin
                present <= 1'b1;
                dev_ls  <= low_speed;
            end
        end
    end

    // R9: the fixed bit 7 never changes.
    a_r9_bit7_fixed: assert property (@(posedge clk) disable iff (!rst_n) ctrl[7]);
    // R9: write-one-to-clear on connect change.
    a_r9_w1c_conn_chg: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst && wdata[PB_CONN_CHG] && !attach) |=> !ctrl[PB_CONN_CHG]);
    // R11: detach always leaves the port disabled.
    a_r11_detach_disables: assert property (@(posedge clk) disable iff (!rst_n)
        detach |=> !ctrl[PB_EN]);
    // R10: a reset pulse lasts one cycle.
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);
endmodule

// File: rtl/usbh_irq_ctl.sv
// Module: status flags, hidden cause bits, interrupt enables and irq level.
// Set pulses win over software clears. Assumes the soft reset clears all.
module usbh_irq_ctl
    import usbh_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               sts_wr,
    input  logic               ien_wr,
    input  logic [15:0]        wdata,
    input  logic [STS_W-1:0]   sts_set,
    input  logic [CAUSE_W-1:0] cause_set,
    output logic [STS_W-1:0]   status,
    output logic [15:0]        ien,
    output logic               irq
);
    logic [CAUSE_W-1:0] cause;
    logic [STS_W-1:0]   sts_nxt;
    logic [CAUSE_W-1:0] cause_nxt;

    // Next status/cause: software clear, then hardware set.
    always_comb begin
        sts_nxt   = status;
        cause_nxt = cause;
        if (sts_wr) begin
            sts_nxt = sts_nxt & ~wdata[STS_W-1:0];
            if (wdata[SB_INT]) cause_nxt = '0;
        end
        sts_nxt   = sts_nxt | sts_set;
        cause_nxt = cause_nxt | cause_set;
        if (|cause_set) sts_nxt[SB_INT] = 1'b1;
    end

    // Register status, causes and enables.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            status <= '0;
            cause  <= '0;
            ien    <= '0;
        end else begin
            status <= sts_nxt;
            cause  <= cause_nxt;
            if (ien_wr) ien <= wdata;
        end
    end

    // Combine causes with enables into the level interrupt.
    always_comb begin
        irq = (cause[0] && ien[2]) || (cause[1] && ien[3]) ||
              (status[SB_ERR] && ien[0]) || (status[SB_RD] && ien[1]) ||
              status[SB_HSE] || status[SB_PERR];
    end

    // R5: a set pulse beats a same-cycle clear.
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && sts_set[SB_ERR]) |=> status[SB_ERR]);
    // R6: system and process errors cannot be masked.
    a_r6_unmaskable: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && (sts_set[SB_HSE] || sts_set[SB_PERR])) |=> irq);
    // R5: a cause pulse raises the interrupt flag.
    a_r5_cause_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && (|cause_set)) |=> status[SB_INT]);
endmodule

// File: rtl/usbh_regfile.sv
// Module: top of the USB host controller register block.
// Decodes a 5-bit byte/word/dword window, holds command, frame number, list
// base and SOF timing, and instantiates the interrupt control and NPORTS
// root-port words. Assumes NPORTS <= 8 (three address bits select a port).
module usbh_regfile
    import usbh_pkg::*;
#(
    parameter int NPORTS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [5:0]        sts_set,
    input  logic [1:0]        cause_set,
    input  logic [NPORTS-1:0] port_attach,
    input  logic [NPORTS-1:0] port_detach,
    input  logic [NPORTS-1:0] port_low_speed,
    output logic              irq,
    output logic              run,
    output logic [10:0]       frame_num,
    output logic [31:0]       list_base,
    output logic              run_start,
    output logic              bus_reset,
    output logic [NPORTS-1:0] port_reset
);
    localparam int FRN_W  = 11;
    localparam int BASE_LOW = 12;

    logic              wr_byte, wr_word, wr_dword;
    logic              cmd_wr, soft_rst;
    logic [15:0]       cmd;
    logic [7:0]        sof;
    logic [STS_W-1:0]  status;
    logic [15:0]       ien;
    logic [15:0]       pctl [NPORTS];
    logic [15:0]       word_rd;

    // Decode the write strobe by size and the command reset requests.
    always_comb begin
        wr_byte  = bus_wr && (bus_size == SZ_BYTE);
        wr_word  = bus_wr && (bus_size == SZ_WORD);
        wr_dword = bus_wr && (bus_size == SZ_DWORD);
        cmd_wr   = wr_word && (bus_addr == A_CMD);
        soft_rst = cmd_wr && (bus_wdata[1] || bus_wdata[2]);
    end

    usbh_irq_ctl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .sts_wr    (wr_word && (bus_addr == A_STS)),
        .ien_wr    (wr_word && (bus_addr == A_IEN)),
        .wdata     (bus_wdata[15:0]),
        .sts_set   (sts_set),
        .cause_set (cause_set),
        .status    (status),
        .ien       (ien),
        .irq       (irq)
    );

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        usbh_port_reg u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .soft_rst  (soft_rst),
            .wr_en     (wr_word && bus_addr[4] && (bus_addr[3:1] == 3'(i))),
            .wdata     (bus_wdata[15:0]),
            .attach    (port_attach[i]),
            .detach    (port_detach[i]),
            .low_speed (port_low_speed[i]),
            .ctrl      (pctl[i]),
            .rst_pulse (port_reset[i])
        );
    end

    // Command word and the run-start / bus-reset pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd       <= '0;
            run_start <= 1'b0;
            bus_reset <= 1'b0;
        end else begin
            run_start <= cmd_wr && !soft_rst && bus_wdata[0] && !cmd[0];
            bus_reset <= cmd_wr && bus_wdata[2];
            if (soft_rst)    cmd <= '0;
            else if (cmd_wr) cmd <= bus_wdata[15:0];
        end
    end

    // Frame number: writable only while halted, kept across soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_num <= '0;
        end else if (wr_word && (bus_addr == A_FRN) && status[SB_HALT]) begin
            frame_num <= bus_wdata[FRN_W-1:0];
        end
    end

    // List base (4 KiB aligned) and start-of-frame timing.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            list_base <= '0;
            sof       <= SOF_RST;
        end else begin
            if (wr_dword && (bus_addr == A_BASE))
                list_base <= {bus_wdata[31:BASE_LOW], {BASE_LOW{1'b0}}};
            if (wr_byte && (bus_addr == A_SOF))
                sof <= bus_wdata[7:0];
        end
    end

    // Word read decode, including port slots beyond NPORTS.
    always_comb begin
        word_rd = WORD_NONE;
        case (bus_addr)
            A_CMD:   word_rd = cmd;
            A_STS:   word_rd = {{(16-STS_W){1'b0}}, status};
            A_IEN:   word_rd = ien;
            A_FRN:   word_rd = {{(16-FRN_W){1'b0}}, frame_num};
            default: begin
                if (bus_addr[4]) begin
                    for (int i = 0; i < NPORTS; i++) begin
                        if (bus_addr[3:1] == 3'(i)) word_rd = pctl[i];
                    end
                end
            end
        endcase
    end

    // Final read mux by transfer size.
    always_comb begin
        case (bus_size)
            SZ_BYTE:  bus_rdata = (bus_addr == A_SOF) ? {24'h0, sof} : 32'h0000_00FF;
            SZ_WORD:  bus_rdata = {16'h0, word_rd};
            SZ_DWORD: bus_rdata = (bus_addr == A_BASE) ? list_base : 32'hFFFF_FFFF;
            default:  bus_rdata = 32'hFFFF_FFFF;
        endcase
    end

    assign run = cmd[0];

    // R7: frame number holds when written outside the halted state.
    a_r7_frn_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word && (bus_addr == A_FRN) && !status[SB_HALT]) |=> $stable(frame_num));
    // R3: a reset command leaves command at zero.
    a_r3_cmd_not_kept: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cmd == 16'h0));
    // R8: list base stays aligned.
    a_r8_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (list_base[BASE_LOW-1:0] == '0));
    // R2: run_start only accompanies a running controller.
    a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |-> run);
endmodule

// File: tb/usbh_regfile_test.sv
`timescale 1ns/1ps
module usbh_regfile_test;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [1:0]    bus_size = 2'd1;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [5:0]    sts_set = '0;
    logic [1:0]    cause_set = '0;
    logic [NP-1:0] port_attach = '0;
    logic [NP-1:0] port_detach = '0;
    logic [NP-1:0] port_low_speed = '0;
    logic          irq, run, run_start, bus_reset;
    logic [10:0]   frame_num;
    logic [31:0]   list_base;
    logic [NP-1:0] port_reset;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    usbh_regfile #(.NPORTS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sts_set(sts_set), .cause_set(cause_set), .port_attach(port_attach),
        .port_detach(port_detach), .port_low_speed(port_low_speed),
        .irq(irq), .run(run), .frame_num(frame_num), .list_base(list_base),
        .run_start(run_start), .bus_reset(bus_reset), .port_reset(port_reset)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sz, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sz, input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_size = sz; bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic pulse(input logic [5:0] s, input logic [1:0] c);
        @(negedge clk);
        sts_set = s; cause_set = c;
        @(negedge clk);
        sts_set = '0; cause_set = '0;
    endtask

    task automatic port_ev(input int p, input bit att, input bit ls);
        @(negedge clk);
        if (att) begin port_attach[p] = 1'b1; port_low_speed[p] = ls; end
        else port_detach[p] = 1'b1;
        @(negedge clk);
        port_attach = '0; port_detach = '0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] pm;
        bit          pres;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(1, 5'h00, v); check("R1 cmd", v, 32'h0);
        rd(1, 5'h02, v); check("R1 status", v, 32'h0);
        rd(1, 5'h04, v); check("R1 ien", v, 32'h0);
        rd(1, 5'h06, v); check("R1 frnum", v, 32'h0);
        rd(2, 5'h08, v); check("R1 base", v, 32'h0);
        rd(0, 5'h0C, v); check("R1 sof", v, 32'd64);
        rd(1, 5'h10, v); check("R1 port0", v, 32'h80);
        rd(1, 5'h12, v); check("R1 port1", v, 32'h80);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R12 decode sweep over all addresses and sizes
        for (int a = 0; a < 32; a++) begin
            logic [31:0] ew;
            if (a == 0 || a == 2 || a == 4 || a == 6) ew = 32'h0;
            else if (a >= 16 && a < 16 + 2*NP) ew = 32'h80;
            else ew = 32'hFF7F;
            rd(1, 5'(a), v); check("R12 word", v, ew);
            rd(2, 5'(a), v); check("R12 dword", v, (a == 8) ? 32'h0 : 32'hFFFF_FFFF);
            rd(0, 5'(a), v); check("R12 byte", v, (a == 12) ? 32'd64 : 32'hFF);
        end

        // R2 command store and run_start
        wr(1, 5'h00, 32'h0001);
        check("R2 run_start", {31'h0, run_start}, 32'h1);
        check("R2 run", {31'h0, run}, 32'h1);
        wr(1, 5'h00, 32'h0081);
        check("R2 no second start", {31'h0, run_start}, 32'h0);
        rd(1, 5'h00, v); check("R2 cmd value", v, 32'h81);

        // R7 frame number gating
        wr(1, 5'h06, 32'h0123);
        rd(1, 5'h06, v); check("R7 locked", v, 32'h0);
        pulse(6'h20, 2'b00);
        wr(1, 5'h06, 32'hFFFF);
        rd(1, 5'h06, v); check("R7 11 bits", v, 32'h7FF);
        wr(1, 5'h06, 32'h0456);
        check("R7 frame_num out", {21'h0, frame_num}, 32'h456);

        // R8 base alignment and SOF byte
        wr(2, 5'h08, 32'hDEADBEEF);
        rd(2, 5'h08, v); check("R8 base", v, 32'hDEADB000);
        wr(0, 5'h0C, 32'h5A);
        rd(0, 5'h0C, v); check("R8 sof", v, 32'h5A);

        // R4/R5 status set, clear and priority
        pulse(6'h1E, 2'b00);
        rd(1, 5'h02, v); check("R5 set", v, 32'h3E);
        wr(1, 5'h02, 32'h0C);
        rd(1, 5'h02, v); check("R4 w1c", v, 32'h32);
        @(negedge clk);
        bus_wr = 1'b1; bus_size = 1; bus_addr = 5'h02; bus_wdata = 32'h02; sts_set = 6'h02;
        @(negedge clk);
        bus_wr = 1'b0; sts_set = '0;
        rd(1, 5'h02, v); check("R5 set wins over clear", v, 32'h32);
        wr(1, 5'h02, 32'h3F);
        rd(1, 5'h02, v); check("R4 clear all", v, 32'h0);

        // R6 sweep of causes/errors against all enable patterns
        for (int c = 0; c < 16; c++) begin
            for (int e = 0; e < 16; e++) begin
                bit exp_irq;
                wr(1, 5'h02, 32'h3F);
                pulse({2'b00, 1'b0, c[3], c[2], 1'b0}, c[1:0]);
                wr(1, 5'h04, 32'(e));
                exp_irq = (c[0] & e[2]) | (c[1] & e[3]) | (c[2] & e[0]) | (c[3] & e[1]);
                check("R6 irq", {31'h0, irq}, {31'h0, exp_irq});
            end
            rd(1, 5'h02, v);
            check("R5 cause raises bit0", {31'h0, v[0]}, {31'h0, (c[1:0] != 0)});
        end
        wr(1, 5'h02, 32'h3F);
        wr(1, 5'h04, 32'h0);
        pulse(6'h08, 2'b00);
        check("R6 system error unmasked", {31'h0, irq}, 32'h1);
        wr(1, 5'h02, 32'h08);
        check("R6 cleared", {31'h0, irq}, 32'h0);
        pulse(6'h10, 2'b00);
        check("R6 process error unmasked", {31'h0, irq}, 32'h1);
        wr(1, 5'h02, 32'h10);

        // R4 hidden cause cleared only by bit 0
        pulse(6'h00, 2'b01);
        wr(1, 5'h04, 32'h4);
        wr(1, 5'h02, 32'h02);
        check("R4 cause kept", {31'h0, irq}, 32'h1);
        wr(1, 5'h02, 32'h01);
        check("R4 cause cleared", {31'h0, irq}, 32'h0);

        // R3 controller reset with a low-speed device on port 0
        port_ev(0, 1'b1, 1'b1);
        pulse(6'h02, 2'b10);
        wr(1, 5'h04, 32'hF);
        wr(1, 5'h00, 32'h0003);
        check("R3 no bus_reset", {31'h0, bus_reset}, 32'h0);
        rd(1, 5'h00, v); check("R3 cmd not stored", v, 32'h0);
        rd(1, 5'h02, v); check("R3 status", v, 32'h0);
        rd(1, 5'h04, v); check("R3 ien", v, 32'h0);
        rd(2, 5'h08, v); check("R3 base", v, 32'h0);
        rd(0, 5'h0C, v); check("R3 sof", v, 32'd64);
        rd(1, 5'h06, v); check("R3 frnum kept", v, 32'h456);
        rd(1, 5'h10, v); check("R3 port0 reconnect", v, 32'h0183);
        rd(1, 5'h12, v); check("R3 port1", v, 32'h80);
        wr(1, 5'h00, 32'h0004);
        check("R3 bus_reset", {31'h0, bus_reset}, 32'h1);
        rd(1, 5'h00, v); check("R3 global not stored", v, 32'h0);

        // R11 attach/detach on port 1
        port_ev(1, 1'b1, 1'b0);
        rd(1, 5'h12, v); check("R11 attach", v, 32'h83);
        port_ev(1, 1'b0, 1'b0);
        rd(1, 5'h12, v); check("R11 detach disabled port", v, 32'h83);
        port_ev(1, 1'b1, 1'b1);
        rd(1, 5'h12, v); check("R11 re-attach speed", v, 32'h183);

        // R9/R10/R11 port 0 write sweep with events interleaved
        pm = 16'h0183; pres = 1'b1;
        for (int k = 0; k < 40; k++) begin
            logic [15:0] wv;
            bit          exp_p;
            if (k == 13) begin
                port_ev(0, 1'b0, 1'b0);
                if (pm[2]) begin pm[2] = 1'b0; pm[3] = 1'b1; end
                pres = 1'b0;
                rd(1, 5'h10, v); check("R11 detach enabled port", v, {16'h0, pm});
            end
            if (k == 27) begin
                port_ev(0, 1'b1, 1'b0);
                if (!pm[0]) begin pm[0] = 1'b1; pm[1] = 1'b1; end
                pm[8] = 1'b0; pres = 1'b1;
                rd(1, 5'h10, v); check("R11 attach", v, {16'h0, pm});
            end
            wv = 16'(k * 16'h0A53) ^ ((k % 3 == 0) ? 16'h0204 : 16'h0000);
            exp_p = wv[9] && !pm[9] && pres;
            pm = ((pm & 16'h01FB) | (wv & ~16'h01FB)) & ~(wv & 16'h000A);
            wr(1, 5'h10, {16'h0, wv});
            check("R10 port_reset", {31'h0, port_reset[0]}, {31'h0, exp_p});
            rd(1, 5'h10, v); check("R9 port merge", v, {16'h0, pm});
        end
        rd(1, 5'h12, v); check("R9 port1 untouched", v, 32'h183);
        wr(1, 5'h16, 32'hFFFF);
        rd(1, 5'h16, v); check("R12 missing port", v, 32'hFF7F);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule